// File: doc/BRIEF.md
# Microcontroller Clock Control Unit

This block produces the timing enables for a small microcontroller core. Every clock is modelled as a one-cycle enable on a single fast clock. Three free-running source enables feed the block: an on-chip ring oscillator, a ceramic resonator and an RC oscillator. A source latch picks one of them. After reset the ring oscillator drives the core until software issues one of two select commands.

A power-of-two prescaler divides the selected source by 1, 2, 4 or 8 to make the system clock enable. The choice comes from a 2-bit mode field. A divide-by-three stage then turns the system clock enable into the instruction clock enable.

A stabilization timer holds the program start signal low after reset, and again after a return from RAM backup, for a fixed number of source ticks. The instruction clock stays gated during that time. Power-down takes two steps: an arm command, then a go command. A key wakeup or the reset pin brings the device out of backup.

Top module: `mcu_clkgen`

## Requirements
- R1: While and right after reset, the ring oscillator is the source, the divide ratio is 8 (mode 11), and all three outputs are low.
- R2: The mode field sets the system clock period to the source tick period times 1, 2, 4 or 8, for codes 00, 01, 10 and 11 respectively.
- R3: A pulse on cmd_sel_xtal makes the ceramic ticks the source, and a pulse on cmd_sel_rc makes the RC ticks the source.
- R4: A change of mode field or source only takes effect at the end of a complete prescaler period, so the period in progress keeps its old length.
- R5: instr_clk_en pulses for exactly one cycle, one cycle after every third system clock enable, so its period is three system clock periods.
- R6: instr_clk_en never pulses while prog_start is low.
- R7: prog_start rises after WAIT_LEN ticks of the active source have been counted, following reset release.
- R8: A cmd_pd_go pulse without an earlier cmd_pd_arm pulse is ignored and the clocks keep running. A go pulse after an arm pulse enters backup.
- R9: In backup, sys_clk_en, instr_clk_en and prog_start stay low.
- R10: key_wake leaves backup and restarts the stabilization wait. The selected source and mode field stay in effect.
- R11: Asserting the reset pin at any time returns the source to the ring oscillator and restarts the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast modelling clock |
| rst_n | input | 1 | Reset pin, active low, asynchronous |
| ring_tick | input | 1 | On-chip ring oscillator tick enable |
| xtal_tick | input | 1 | Ceramic resonator tick enable |
| rc_tick | input | 1 | RC oscillator tick enable |
| mode_field | input | MODE_W | Divide select: 00=/1, 01=/2, 10=/4, 11=/8 |
| cmd_sel_xtal | input | 1 | Select-ceramic command strobe |
| cmd_sel_rc | input | 1 | Select-RC command strobe |
| cmd_pd_arm | input | 1 | Power-down enable command strobe |
| cmd_pd_go | input | 1 | Power-down command strobe |
| key_wake | input | 1 | Key-on wakeup request |
| sys_clk_en | output | 1 | System clock enable pulse |
| instr_clk_en | output | 1 | Instruction clock enable pulse |
| prog_start | output | 1 | High once the stabilization wait has elapsed |

## Verification
A wrong prescaler count or a wrong active mode shows as a wrong spacing between sys_clk_en pulses within one system period. A wrong source latch shows the same way, because each source ticks at its own rate. A slip in the divide-by-three counter shows at the next instruction pulse as a spacing other than three system periods. A stabilization timer that is wrong moves the rising edge of prog_start by whole source ticks, and this shows within a few tens of cycles of reset or wakeup. A broken backup latch either lets sys_clk_en pulse during backup or stops it after an unarmed go command. The bench catches that within one prescaler period.

// File: rtl/mcu_clk_pkg.sv
package mcu_clk_pkg;
   typedef enum logic [1:0] {
      SRC_RING = 2'd0,
      SRC_XTAL = 2'd1,
      SRC_RC   = 2'd2
   } clk_src_e;
endpackage

// File: rtl/clk_src_latch.sv
module clk_src_latch
   import mcu_clk_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     sel_xtal,
   input  logic     sel_rc,
   input  logic     frozen,
   output clk_src_e req_src
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         req_src <= SRC_RING;
      else if (!frozen) begin
         if (sel_xtal)
            req_src <= SRC_XTAL;
         else if (sel_rc)
            req_src <= SRC_RC;
      end
   end
endmodule

// File: rtl/clk_prescaler.sv
module clk_prescaler
   import mcu_clk_pkg::*;
#(
   parameter int MODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ring_tick,
   input  logic              xtal_tick,
   input  logic              rc_tick,
   input  clk_src_e          req_src,
   input  logic [MODE_W-1:0] req_mode,
   input  logic              hold,
   output logic              src_tick,
   output logic              term_hit,
   output clk_src_e          act_src,
   output logic [MODE_W-1:0] act_mode,
   output logic              sys_q
);
   localparam int MAX_SHIFT = (1 << MODE_W) - 1;
   localparam int MAX_RATIO = 1 << MAX_SHIFT;
   localparam int CNT_W     = (MAX_RATIO > 2) ? $clog2(MAX_RATIO) : 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W:0]   ratio;
   logic [CNT_W-1:0] last;

   always_comb begin
      unique case (act_src)
         SRC_XTAL: src_tick = xtal_tick;
         SRC_RC:   src_tick = rc_tick;
         default:  src_tick = ring_tick;
      endcase
   end

   assign ratio    = (CNT_W+1)'(1) << act_mode;
   assign last     = CNT_W'(ratio - (CNT_W+1)'(1));
   assign term_hit = src_tick && !hold && (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         act_src  <= SRC_RING;
         act_mode <= '1;
         sys_q    <= 1'b0;
      end else begin
         sys_q <= term_hit;
         if (term_hit) begin
            cnt      <= '0;
            act_src  <= req_src;
            act_mode <= req_mode;
         end else if (src_tick && !hold) begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/clk_wait_timer.sv
module clk_wait_timer #(
   parameter int WAIT_LEN = 16384
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic restart,
   input  logic hold,
   output logic done
);
   localparam int WCNT_W = $clog2(WAIT_LEN + 1);

   logic [WCNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (restart) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (!hold && !done && tick) begin
         if (cnt == WCNT_W'(WAIT_LEN - 1))
            done <= 1'b1;
         else
            cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/instr_divider.sv
module instr_divider #(
   parameter int DIV = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sys_en,
   input  logic run,
   output logic pulse
);
   generate
      if (DIV == 1) begin : g_pass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse <= 1'b0;
            else        pulse <= sys_en && run;
         end
      end else begin : g_count
         localparam int DCW = $clog2(DIV);
         logic [DCW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt   <= '0;
               pulse <= 1'b0;
            end else if (!run) begin
               cnt   <= '0;
               pulse <= 1'b0;
            end else if (sys_en) begin
               if (cnt == DCW'(DIV - 1)) begin
                  cnt   <= '0;
                  pulse <= 1'b1;
               end else begin
                  cnt   <= cnt + 1'b1;
                  pulse <= 1'b0;
               end
            end else begin
               pulse <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/mcu_clkgen.sv
module mcu_clkgen
   import mcu_clk_pkg::*;
#(
   parameter int MODE_W    = 2,
   parameter int WAIT_LEN  = 16384,
   parameter int INSTR_DIV = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ring_tick,
   input  logic              xtal_tick,
   input  logic              rc_tick,
   input  logic [MODE_W-1:0] mode_field,
   input  logic              cmd_sel_xtal,
   input  logic              cmd_sel_rc,
   input  logic              cmd_pd_arm,
   input  logic              cmd_pd_go,
   input  logic              key_wake,
   output logic              sys_clk_en,
   output logic              instr_clk_en,
   output logic              prog_start
);
   if (MODE_W < 1 || MODE_W > 3) begin : g_bad_mode
      $error("MODE_W must be 1 to 3");
   end
   if (WAIT_LEN < 1) begin : g_bad_wait
      $error("WAIT_LEN must be at least 1");
   end
   if (INSTR_DIV < 1) begin : g_bad_div
      $error("INSTR_DIV must be at least 1");
   end

   logic              backup;
   logic              armed;
   logic              pd_enter;
   logic              wake_exit;
   clk_src_e          req_src;
   clk_src_e          act_src;
   logic [MODE_W-1:0] act_mode;
   logic              src_tick;
   logic              term_hit;

   assign pd_enter  = cmd_pd_go && armed && !backup;
   assign wake_exit = backup && key_wake;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed  <= 1'b0;
         backup <= 1'b0;
      end else begin
         if (pd_enter)        armed <= 1'b0;
         else if (cmd_pd_arm) armed <= 1'b1;
         if (pd_enter)        backup <= 1'b1;
         else if (wake_exit)  backup <= 1'b0;
      end
   end

   clk_src_latch u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_xtal (cmd_sel_xtal),
      .sel_rc   (cmd_sel_rc),
      .frozen   (backup),
      .req_src  (req_src)
   );

   clk_prescaler #(.MODE_W(MODE_W)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .ring_tick (ring_tick),
      .xtal_tick (xtal_tick),
      .rc_tick   (rc_tick),
      .req_src   (req_src),
      .req_mode  (mode_field),
      .hold      (backup),
      .src_tick  (src_tick),
      .term_hit  (term_hit),
      .act_src   (act_src),
      .act_mode  (act_mode),
      .sys_q     (sys_clk_en)
   );

   clk_wait_timer #(.WAIT_LEN(WAIT_LEN)) u_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (src_tick),
      .restart (pd_enter | wake_exit),
      .hold    (backup),
      .done    (prog_start)
   );

   instr_divider #(.DIV(INSTR_DIV)) u_idiv (
      .clk    (clk),
      .rst_n  (rst_n),
      .sys_en (sys_clk_en),
      .run    (prog_start),
      .pulse  (instr_clk_en)
   );
endmodule

// File: rtl/mcu_clkgen_chk.sv
module mcu_clkgen_chk #(
   parameter int MODE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sys_clk_en,
   input logic              instr_clk_en,
   input logic              prog_start,
   input logic              backup,
   input logic              term_hit,
   input logic [1:0]        act_src,
   input logic [MODE_W-1:0] act_mode
);
   // R5
   instr_after_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
      instr_clk_en |-> $past(sys_clk_en));

   // R6
   instr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      instr_clk_en |-> $past(prog_start));

   // R4
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !term_hit |=> $stable(act_mode));

   // R4
   src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !term_hit |=> $stable(act_src));

   // R9
   backup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      backup |=> (!sys_clk_en && !prog_start));

   // R9
   start_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_start) |-> !backup);
endmodule

bind mcu_clkgen mcu_clkgen_chk #(.MODE_W(MODE_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sys_clk_en   (sys_clk_en),
   .instr_clk_en (instr_clk_en),
   .prog_start   (prog_start),
   .backup       (backup),
   .term_hit     (term_hit),
   .act_src      (act_src),
   .act_mode     (act_mode)
);

// File: tb/mcu_clkgen_bench.sv
module mcu_clkgen_bench;
   localparam int NVEC = 8;
   // command: 0 none, 1 ceramic, 2 RC; tick periods ring 2, ceramic 1, RC 3
   localparam int VEC_CMD [NVEC] = '{0, 0, 1, 1, 1, 2, 2, 1};
   localparam int VEC_MODE[NVEC] = '{3, 0, 0, 1, 2, 3, 1, 3};
   localparam int VEC_PER [NVEC] = '{16, 2, 1, 2, 4, 24, 6, 8};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ring_tick = 1'b0, xtal_tick = 1'b0, rc_tick = 1'b0;
   logic [1:0] mode_field = 2'b11;
   logic       cmd_sel_xtal = 1'b0, cmd_sel_rc = 1'b0;
   logic       cmd_pd_arm = 1'b0, cmd_pd_go = 1'b0, key_wake = 1'b0;
   logic       sys_clk_en, instr_clk_en, prog_start;

   int n_chk = 0;
   int n_fail = 0;
   int ph = 0;
   int early_instr = 0;

   always #5 clk = ~clk;

   always @(posedge clk) begin
      ph        <= ph + 1;
      ring_tick <= (ph % 2 == 0);
      xtal_tick <= 1'b1;
      rc_tick   <= (ph % 3 == 0);
   end

   always @(negedge clk)
      if (rst_n && instr_clk_en && !prog_start) early_instr = early_instr + 1;

   mcu_clkgen #(.MODE_W(2), .WAIT_LEN(16), .INSTR_DIV(3)) u_mcu_clkgen (
      .clk          (clk),
      .rst_n        (rst_n),
      .ring_tick    (ring_tick),
      .xtal_tick    (xtal_tick),
      .rc_tick      (rc_tick),
      .mode_field   (mode_field),
      .cmd_sel_xtal (cmd_sel_xtal),
      .cmd_sel_rc   (cmd_sel_rc),
      .cmd_pd_arm   (cmd_pd_arm),
      .cmd_pd_go    (cmd_pd_go),
      .key_wake     (key_wake),
      .sys_clk_en   (sys_clk_en),
      .instr_clk_en (instr_clk_en),
      .prog_start   (prog_start)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic next_sys(output int t);
      @(negedge clk);
      while (!sys_clk_en) @(negedge clk);
      t = ph;
   endtask

   task automatic next_instr(output int t);
      @(negedge clk);
      while (!instr_clk_en) @(negedge clk);
      t = ph;
   endtask

   task automatic sys_period(output int p);
      int t0, t1;
      for (int k = 0; k < 3; k++) next_sys(t0);
      next_sys(t1);
      p = t1 - t0;
   endtask

   task automatic count_sys(input int n, output int c, output int starts);
      c = 0; starts = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (sys_clk_en) c++;
         if (prog_start || instr_clk_en) starts++;
      end
   endtask

   task automatic strobe(input int which);
      @(negedge clk);
      case (which)
         1: cmd_sel_xtal = 1'b1;
         2: cmd_sel_rc   = 1'b1;
         3: cmd_pd_arm   = 1'b1;
         4: cmd_pd_go    = 1'b1;
         5: key_wake     = 1'b1;
         default: ;
      endcase
      @(negedge clk);
      cmd_sel_xtal = 1'b0; cmd_sel_rc = 1'b0;
      cmd_pd_arm = 1'b0; cmd_pd_go = 1'b0; key_wake = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      int p, t0, t1, t2, c, s;
      repeat (4) @(negedge clk);
      // R1 outputs low during reset
      check(!sys_clk_en && !instr_clk_en && !prog_start, "R1",
            {sys_clk_en, instr_clk_en, prog_start}, 0);
      rst_n = 1'b1;
      // R7 wait of 16 ring ticks (about 32 cycles)
      repeat (28) @(negedge clk);
      check(prog_start == 1'b0, "R7 early", prog_start, 0);
      repeat (8) @(negedge clk);
      check(prog_start == 1'b1, "R7 late", prog_start, 1);
      // R6 no instruction pulse before start
      check(early_instr == 0, "R6", early_instr, 0);

      // R2 R3 R5 vector walk
      for (int i = 0; i < NVEC; i++) begin
         mode_field = 2'(VEC_MODE[i]);
         if (VEC_CMD[i] != 0) strobe(VEC_CMD[i]);
         sys_period(p);
         check(p == VEC_PER[i], VEC_CMD[i] != 0 ? "R3 source" : "R2 mode", p, VEC_PER[i]);
         next_instr(t0);
         next_instr(t1);
         check(t1 - t0 == 3 * VEC_PER[i], "R5", t1 - t0, 3 * VEC_PER[i]);
      end

      // R4 mode change waits for the running period (ceramic, /8)
      next_sys(t0);
      mode_field = 2'b00;
      next_sys(t1);
      check(t1 - t0 == 8, "R4 old period", t1 - t0, 8);
      next_sys(t2);
      check(t2 - t1 == 1, "R4 new period", t2 - t1, 1);

      // R8 go without arm is ignored
      strobe(4);
      count_sys(40, c, s);
      check(c == 40, "R8 unarmed", c, 40);
      check(prog_start == 1'b1, "R8 start kept", prog_start, 1);

      // R8 R9 arm then go enters backup
      strobe(3);
      strobe(4);
      @(negedge clk);
      count_sys(60, c, s);
      check(c == 0, "R9 sys quiet", c, 0);
      check(s == 0, "R9 start/instr quiet", s, 0);

      // R10 wake restarts wait, keeps ceramic /1
      strobe(5);
      check(prog_start == 1'b0, "R10 wait restart", prog_start, 0);
      repeat (30) @(negedge clk);
      check(prog_start == 1'b1, "R10 start", prog_start, 1);
      sys_period(p);
      check(p == 1, "R10 setting kept", p, 1);

      // R11 reset returns to ring source
      mode_field = 2'b11;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(!prog_start && !sys_clk_en, "R11 reset outputs", prog_start, 0);
      rst_n = 1'b1;
      sys_period(p);
      check(p == 16, "R11 ring source", p, 16);
      repeat (40) @(negedge clk);
      check(prog_start == 1'b1, "R11 start", prog_start, 1);

      finish_run();
   end
endmodule